// File: doc/BRIEF.md
# Three-Slot Layered Schedule Sequencer

This block drives the memory side of a layered parity-check decoder whose datapath works on three block-columns at once. A list of submatrix entries is loaded through a small write port. Each entry names a global block-column, a cyclic rotation and a flag that closes a check-node group. The load path sends each column to the slot whose APP RAM holds it and turns it into that slot's local word address. Each list index is one issue cycle. A slot that has no entry at an index sits idle in that cycle.

After a start pulse the sequencer walks the list once per iteration. In each issue cycle it gives every slot a read enable, a local address and a rotation amount, and it marks the first and last cycle of each check-node group. Every read address comes back out as a write-back address a fixed number of cycles later. A scoreboard follows the addresses still in the pipeline. If a read would fetch a word that an earlier group has not yet written back, all three slots wait together. Decoding ends after a programmed number of iterations, or sooner when the datapath reports that every parity check holds. The pipeline is then drained and a one-cycle completion pulse is given.

The controller has four states. IDLE waits for `start`. ISSUE walks the list and stalls on hazards. DRAIN flushes the pipeline for the fixed latency. FINISH raises `done` for one cycle. The transitions are: IDLE→ISSUE on `start`; ISSUE→ISSUE while issuing or stalled; ISSUE→DRAIN when the last entry of the final iteration issues; DRAIN→FINISH after the latency count; FINISH→IDLE unconditionally.

Top module: `tri_slot_sequencer`

## Requirements
- R1: After reset, and whenever the block is idle, `busy`, `done`, `stall`, `row_first`, `row_last`, every `rd_en` bit and every `wb_en` bit are 0, and `iter_cnt` is 0 after reset.
- R2: A load of column c at list index i goes to slot c mod 3 as local address c div 3. At issue, slot s reports on `rd_en[s]`, `rd_addr[s*4 +: 4]` and `rd_shift[s*5 +: 5]`.
- R3: The rotation is issued exactly as it was loaded. A load whose rotation is 30 or more, or whose column is 48 or more, is dropped and leaves the stored list unchanged.
- R4: A load with `cfg_idle` set makes slot c mod 3 idle at that index, so its `rd_en` bit stays 0 when the index issues. After reset every slot is idle at every index.
- R5: Each slot's `wb_en` and `wb_addr` repeat its `rd_en` and `rd_addr` exactly 4 cycles later.
- R6: If a slot's next address matches an address that an earlier group read and that is still among the 4 in-flight cycles, `stall` is 1 and all `rd_en` bits are 0. The read issues in the cycle after that address's write-back cycle.
- R7: No stall occurs for addresses within the same group, for the same local address on a different slot, or for addresses that are not in flight.
- R8: `row_first` is 1 on the issue of list index 0 and on the issue of any index that follows an index loaded with the group-end flag. `row_last` is 1 on the issue of an index whose group-end flag is set.
- R9: After index `list_len-1` issues, `iter_cnt` increments. The run ends when `iter_cnt` reaches `max_iter` (0 counts as 1), or when `chk_ok` is 1 in the cycle the last index issues. Otherwise the walk restarts at index 0.
- R10: After the final issue, 4 drain cycles follow. `done` is then 1 for exactly one cycle, and `busy` is 0 in the cycle after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | List write strobe |
| cfg_idx | input | 5 | List index (issue cycle) written |
| cfg_col | input | 6 | Global block-column of the entry |
| cfg_idle | input | 1 | Mark the selected slot idle at this index |
| cfg_shift | input | 5 | Cyclic rotation, 0..29 |
| cfg_grp_end | input | 1 | Group-end flag for this index |
| list_len | input | 6 | Number of list indices per iteration |
| max_iter | input | 4 | Iteration limit (0 counts as 1) |
| start | input | 1 | Begin a decode run when idle |
| chk_ok | input | 1 | All parity checks satisfied |
| rd_en | output | 3 | Per-slot APP read enable |
| rd_addr | output | 12 | Per-slot local read address, 4 bits each |
| rd_shift | output | 15 | Per-slot rotation, 5 bits each |
| row_first | output | 1 | First issue of a check-node group |
| row_last | output | 1 | Last issue of a check-node group |
| stall | output | 1 | Hazard bubble on all slots |
| wb_en | output | 3 | Per-slot write-back enable |
| wb_addr | output | 12 | Per-slot write-back address, 4 bits each |
| iter_cnt | output | 4 | Completed iterations in this run |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest case to reach is a read-after-write hazard. It needs a slot to request a word that a different group read only a few cycles earlier. Adjacent groups that each hold one entry on the same slot and local address do this, and the bench counts the bubbles and the cycle in which the read is finally released. The bench also reaches a hazard at the iteration wrap: with a two-index list, index 0 of the next iteration meets its own still-pending word from the previous pass. A third pattern repeats one local address on a different slot, and places two addresses in one group, to show that neither case causes a stall.

// File: rtl/tri_slot_pkg.sv
package tri_slot_pkg;
    localparam int NUM_SLOTS = 3;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_DRAIN,
        ST_FINISH
    } seq_state_t;
endpackage

// File: rtl/tri_slot_vec_store.sv
module tri_slot_vec_store #(
    parameter int VEC_DEPTH = 32,
    parameter int ADDR_W    = 4,
    parameter int SHIFT_W   = 5,
    parameter int Z         = 30,
    localparam int IDX_W    = $clog2(VEC_DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic               wr_idle,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [SHIFT_W-1:0] wr_shift,
    input  logic [IDX_W-1:0]   rd_idx,
    output logic               ent_act,
    output logic [ADDR_W-1:0]  ent_addr,
    output logic [SHIFT_W-1:0] ent_shift
);
    localparam logic [SHIFT_W-1:0] Z_L = SHIFT_W'(Z);

    logic               act_q   [VEC_DEPTH];
    logic [ADDR_W-1:0]  addr_q  [VEC_DEPTH];
    logic [SHIFT_W-1:0] shift_q [VEC_DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < VEC_DEPTH; i++) begin
                act_q[i]   <= 1'b0;
                addr_q[i]  <= '0;
                shift_q[i] <= '0;
            end
        end else if (wr_en) begin
            act_q[wr_idx]   <= !wr_idle;
            addr_q[wr_idx]  <= wr_addr;
            shift_q[wr_idx] <= wr_shift;
        end
    end

    always_comb begin
        ent_act   = act_q[rd_idx];
        ent_addr  = addr_q[rd_idx];
        ent_shift = shift_q[rd_idx];
    end

    // R3: a filtered load path never leaves an out-of-range rotation in an active entry
    assert_shift_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ent_act |-> (ent_shift < Z_L));
endmodule

// File: rtl/tri_slot_hazard.sv
module tri_slot_hazard #(
    parameter int ADDR_W   = 4,
    parameter int PIPE_LAT = 4,
    localparam int CNT_W   = $clog2(PIPE_LAT + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cand_act,
    input  logic [ADDR_W-1:0] cand_addr,
    input  logic              issue,
    input  logic [CNT_W-1:0]  mask_n,
    output logic              hit,
    output logic              wb_en,
    output logic [ADDR_W-1:0] wb_addr
);
    logic              v_q [PIPE_LAT];
    logic [ADDR_W-1:0] a_q [PIPE_LAT];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int j = 0; j < PIPE_LAT; j++) begin
                v_q[j] <= 1'b0;
                a_q[j] <= '0;
            end
        end else begin
            v_q[0] <= issue && cand_act;
            a_q[0] <= cand_addr;
            for (int j = 1; j < PIPE_LAT; j++) begin
                v_q[j] <= v_q[j-1];
                a_q[j] <= a_q[j-1];
            end
        end
    end

    always_comb begin
        hit = 1'b0;
        for (int j = 0; j < PIPE_LAT; j++) begin
            if (j >= int'(mask_n) && v_q[j] && a_q[j] == cand_addr && cand_act)
                hit = 1'b1;
        end
        wb_en   = v_q[PIPE_LAT-1];
        wb_addr = a_q[PIPE_LAT-1];
    end

    // R6: the controller must not issue a read to a word still pending from an earlier group
    assert_no_read_on_hit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> !issue);
endmodule

// File: rtl/tri_slot_ctrl.sv
module tri_slot_ctrl
    import tri_slot_pkg::*;
#(
    parameter int VEC_DEPTH = 32,
    parameter int PIPE_LAT  = 4,
    parameter int ITER_W    = 4,
    localparam int IDX_W    = $clog2(VEC_DEPTH),
    localparam int LEN_W    = IDX_W + 1,
    localparam int CNT_W    = $clog2(PIPE_LAT + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              chk_ok,
    input  logic [LEN_W-1:0]  list_len,
    input  logic [ITER_W-1:0] max_iter,
    input  logic              gend_we,
    input  logic [IDX_W-1:0]  gend_idx,
    input  logic              gend_val,
    input  logic              any_hit,
    output logic [IDX_W-1:0]  ptr,
    output logic              issue,
    output logic              stall,
    output logic              row_first,
    output logic              row_last,
    output logic [CNT_W-1:0]  mask_n,
    output logic              busy,
    output logic              done,
    output logic [ITER_W-1:0] iter_cnt
);
    localparam logic [CNT_W-1:0] LAT_L  = CNT_W'(PIPE_LAT);
    localparam logic [CNT_W-1:0] LAT_M1 = CNT_W'(PIPE_LAT - 1);

    seq_state_t        state_q, state_d;
    logic [VEC_DEPTH-1:0] gend_q;
    logic [CNT_W-1:0]  row_cnt_q, drain_q, row_inc;
    logic [ITER_W:0]   iter_next, max_eff;
    logic [IDX_W-1:0]  prev_idx;
    logic              cur_first, at_last, final_iter;

    always_ff @(posedge clk) begin
        if (!rst_n) gend_q <= '0;
        else if (gend_we) gend_q[gend_idx] <= gend_val;
    end

    always_comb begin
        prev_idx   = ptr - 1'b1;
        cur_first  = (ptr == '0) || gend_q[prev_idx];
        at_last    = ({1'b0, ptr} + 1'b1) >= list_len;
        iter_next  = {1'b0, iter_cnt} + 1'b1;
        max_eff    = (max_iter == '0) ? (ITER_W+1)'(1) : {1'b0, max_iter};
        final_iter = chk_ok || (iter_next >= max_eff);
        row_inc    = (row_cnt_q == LAT_L) ? LAT_L : row_cnt_q + 1'b1;
        mask_n     = cur_first ? '0 : row_cnt_q;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_ISSUE;
            ST_ISSUE:  if (!any_hit && at_last && final_iter) state_d = ST_DRAIN;
            ST_DRAIN:  if (drain_q == LAT_M1) state_d = ST_FINISH;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        issue     = 1'b0;
        stall     = 1'b0;
        busy      = 1'b0;
        done      = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_ISSUE: begin
                busy  = 1'b1;
                issue = !any_hit;
                stall = any_hit;
            end
            ST_DRAIN:  busy = 1'b1;
            ST_FINISH: begin
                busy = 1'b1;
                done = 1'b1;
            end
            default:   ;
        endcase
        row_first = issue && cur_first;
        row_last  = issue && gend_q[ptr];
    end

    // list pointer, group-age counter, drain counter, iteration counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr       <= '0;
            row_cnt_q <= '0;
            drain_q   <= '0;
            iter_cnt  <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start) begin
                    ptr       <= '0;
                    row_cnt_q <= '0;
                    iter_cnt  <= '0;
                end
                ST_ISSUE: begin
                    if (issue) begin
                        row_cnt_q <= cur_first ? CNT_W'(1) : row_inc;
                        if (at_last) begin
                            ptr      <= '0;
                            iter_cnt <= iter_next[ITER_W-1:0];
                            drain_q  <= '0;
                        end else begin
                            ptr <= ptr + 1'b1;
                        end
                    end else if (!cur_first) begin
                        row_cnt_q <= row_inc;
                    end
                end
                ST_DRAIN:  drain_q <= drain_q + 1'b1;
                ST_FINISH: ;
                default:   ;
            endcase
        end
    end

    // R10: completion is a single-cycle pulse
    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R10: completion only follows the drain phase
    assert_done_after_drain_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(state_q == ST_DRAIN));
    // R6: a bubble cycle never marks a group start
    assert_stall_bubble_R6: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> (!issue && !row_first && !row_last));
    // R9: a finished run has completed at least one iteration
    assert_iter_nonzero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (iter_cnt != '0));
endmodule

// File: rtl/tri_slot_sequencer.sv
module tri_slot_sequencer
    import tri_slot_pkg::*;
#(
    parameter int VEC_DEPTH = 32,
    parameter int APP_DEPTH = 16,
    parameter int Z         = 30,
    parameter int PIPE_LAT  = 4,
    parameter int ITER_W    = 4,
    localparam int IDX_W    = $clog2(VEC_DEPTH),
    localparam int LEN_W    = IDX_W + 1,
    localparam int ADDR_W   = $clog2(APP_DEPTH),
    localparam int COL_W    = ADDR_W + 2,
    localparam int SHIFT_W  = $clog2(Z),
    localparam int CNT_W    = $clog2(PIPE_LAT + 1)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cfg_we,
    input  logic [IDX_W-1:0]              cfg_idx,
    input  logic [COL_W-1:0]              cfg_col,
    input  logic                          cfg_idle,
    input  logic [SHIFT_W-1:0]            cfg_shift,
    input  logic                          cfg_grp_end,
    input  logic [LEN_W-1:0]              list_len,
    input  logic [ITER_W-1:0]             max_iter,
    input  logic                          start,
    input  logic                          chk_ok,
    output logic [NUM_SLOTS-1:0]          rd_en,
    output logic [NUM_SLOTS*ADDR_W-1:0]   rd_addr,
    output logic [NUM_SLOTS*SHIFT_W-1:0]  rd_shift,
    output logic                          row_first,
    output logic                          row_last,
    output logic                          stall,
    output logic [NUM_SLOTS-1:0]          wb_en,
    output logic [NUM_SLOTS*ADDR_W-1:0]   wb_addr,
    output logic [ITER_W-1:0]             iter_cnt,
    output logic                          busy,
    output logic                          done
);
    localparam logic [SHIFT_W-1:0] Z_L     = SHIFT_W'(Z);
    localparam logic [COL_W-1:0]   DEPTH_L = COL_W'(APP_DEPTH);

    logic [COL_W-1:0]     col_slot, col_loc;
    logic                 accept;
    logic [IDX_W-1:0]     ptr;
    logic                 issue;
    logic [CNT_W-1:0]     mask_n;
    logic [NUM_SLOTS-1:0] hit, ent_act;

    always_comb begin
        col_slot = cfg_col % COL_W'(NUM_SLOTS);
        col_loc  = cfg_col / COL_W'(NUM_SLOTS);
        accept   = cfg_we && (cfg_shift < Z_L) && (col_loc < DEPTH_L);
    end

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        logic [ADDR_W-1:0] ent_addr;
        logic [SHIFT_W-1:0] ent_shift;

        tri_slot_vec_store #(
            .VEC_DEPTH(VEC_DEPTH), .ADDR_W(ADDR_W), .SHIFT_W(SHIFT_W), .Z(Z)
        ) u_store (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (accept && (col_slot == COL_W'(s))),
            .wr_idx   (cfg_idx),
            .wr_idle  (cfg_idle),
            .wr_addr  (col_loc[ADDR_W-1:0]),
            .wr_shift (cfg_shift),
            .rd_idx   (ptr),
            .ent_act  (ent_act[s]),
            .ent_addr (ent_addr),
            .ent_shift(ent_shift)
        );

        tri_slot_hazard #(
            .ADDR_W(ADDR_W), .PIPE_LAT(PIPE_LAT)
        ) u_hazard (
            .clk      (clk),
            .rst_n    (rst_n),
            .cand_act (ent_act[s]),
            .cand_addr(ent_addr),
            .issue    (issue),
            .mask_n   (mask_n),
            .hit      (hit[s]),
            .wb_en    (wb_en[s]),
            .wb_addr  (wb_addr[s*ADDR_W +: ADDR_W])
        );

        always_comb begin
            rd_en[s]                       = issue && ent_act[s];
            rd_addr[s*ADDR_W +: ADDR_W]    = ent_addr;
            rd_shift[s*SHIFT_W +: SHIFT_W] = ent_shift;
        end
    end

    tri_slot_ctrl #(
        .VEC_DEPTH(VEC_DEPTH), .PIPE_LAT(PIPE_LAT), .ITER_W(ITER_W)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .chk_ok   (chk_ok),
        .list_len (list_len),
        .max_iter (max_iter),
        .gend_we  (accept),
        .gend_idx (cfg_idx),
        .gend_val (cfg_grp_end),
        .any_hit  (|hit),
        .ptr      (ptr),
        .issue    (issue),
        .stall    (stall),
        .row_first(row_first),
        .row_last (row_last),
        .mask_n   (mask_n),
        .busy     (busy),
        .done     (done),
        .iter_cnt (iter_cnt)
    );

    // R1: an idle sequencer neither reads nor writes back
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (rd_en == '0 && wb_en == '0 && !stall));
    // R5: a write-back never appears before the pipeline has had a read to carry
    assert_wb_follows_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_en != '0) |-> busy);
endmodule

// File: tb/tri_slot_sequencer_bench.sv
module tri_slot_sequencer_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we, cfg_idle, cfg_grp_end, start, chk_ok;
    logic [4:0]  cfg_idx, cfg_shift;
    logic [5:0]  cfg_col, list_len;
    logic [3:0]  max_iter, iter_cnt;
    logic [2:0]  rd_en, wb_en;
    logic [11:0] rd_addr, wb_addr;
    logic [14:0] rd_shift;
    logic        row_first, row_last, stall, busy, done;

    integer checks = 0;
    integer errors = 0;

    always #4 clk = ~clk;

    tri_slot_sequencer u_tri_slot_sequencer (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_col(cfg_col), .cfg_idle(cfg_idle), .cfg_shift(cfg_shift),
        .cfg_grp_end(cfg_grp_end), .list_len(list_len), .max_iter(max_iter),
        .start(start), .chk_ok(chk_ok), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_shift(rd_shift), .row_first(row_first), .row_last(row_last),
        .stall(stall), .wb_en(wb_en), .wb_addr(wb_addr), .iter_cnt(iter_cnt),
        .busy(busy), .done(done)
    );

    task automatic chk(input string req, input integer act, input integer exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; cfg_we = 0; cfg_idle = 0; cfg_grp_end = 0; start = 0;
        chk_ok = 0; cfg_idx = 0; cfg_shift = 0; cfg_col = 0;
        list_len = 1; max_iter = 1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic load(input int idx, input int col, input bit idle,
                        input int sh, input bit gend);
        cfg_we = 1; cfg_idx = 5'(idx); cfg_col = 6'(col); cfg_idle = idle;
        cfg_shift = 5'(sh); cfg_grp_end = gend;
        @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic kick();
        start = 1;
        @(negedge clk);
        start = 0;
    endtask

    task automatic wait_done(output integer reads, output integer firsts);
        reads = 0; firsts = 0;
        for (int i = 0; i < 300 && !done; i++) begin
            if (rd_en != 0) reads++;
            if (row_first) firsts++;
            @(negedge clk);
        end
        chk("R10 done reached", done, 1);
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 busy", busy, 0);
        chk("R1 rd_en", rd_en, 0);
        chk("R1 wb_en", wb_en, 0);
        chk("R1 done", done, 0);
        chk("R1 iter_cnt", iter_cnt, 0);
        chk("R1 stall", stall, 0);
    endtask

    task automatic t_mapping();
        do_reset();
        load(0, 3, 0, 0, 1);
        load(0, 7, 0, 13, 1);
        load(0, 11, 0, 29, 1);
        list_len = 1; max_iter = 1;
        kick();
        chk("R2 rd_en all", rd_en, 3'b111);
        chk("R2 slot0 addr", rd_addr[3:0], 1);
        chk("R2 slot1 addr", rd_addr[7:4], 2);
        chk("R2 slot2 addr", rd_addr[11:8], 3);
        chk("R3 slot0 shift", rd_shift[4:0], 0);
        chk("R3 slot1 shift", rd_shift[9:5], 13);
        chk("R3 slot2 shift", rd_shift[14:10], 29);
        chk("R8 first", row_first, 1);
        chk("R8 last", row_last, 1);
        repeat (3) begin
            @(negedge clk);
            chk("R5 wb early", wb_en, 0);
        end
        @(negedge clk);
        chk("R5 wb_en", wb_en, 3'b111);
        chk("R5 wb slot1", wb_addr[7:4], 2);
        chk("R5 wb slot2", wb_addr[11:8], 3);
        chk("R10 not done in drain", done, 0);
        @(negedge clk);
        chk("R10 done", done, 1);
        chk("R9 iter_cnt", iter_cnt, 1);
        @(negedge clk);
        chk("R10 done pulse", done, 0);
        chk("R10 busy low", busy, 0);
    endtask

    task automatic t_idle_and_reject();
        do_reset();
        load(0, 3, 0, 4, 1);
        load(0, 3, 0, 30, 1);
        load(0, 51, 0, 9, 1);
        load(0, 7, 0, 5, 1);
        load(0, 7, 1, 0, 1);
        kick();
        chk("R4 idle slots", rd_en, 3'b001);
        chk("R3 rejected keep addr", rd_addr[3:0], 1);
        chk("R3 rejected keep shift", rd_shift[4:0], 4);
        repeat (6) @(negedge clk);
    endtask

    task automatic t_hazard();
        integer stalls;
        do_reset();
        load(0, 6, 0, 1, 1);
        load(1, 6, 0, 2, 1);
        list_len = 2; max_iter = 1;
        kick();
        chk("R6 first read", rd_en, 3'b001);
        stalls = 0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            if (stall && rd_en == 0) stalls++;
        end
        chk("R6 stall cycles", stalls, 4);
        @(negedge clk);
        chk("R6 released read", rd_en, 3'b001);
        chk("R6 released addr", rd_addr[3:0], 2);
        chk("R6 stall cleared", stall, 0);
        chk("R8 second group first", row_first, 1);
        repeat (8) @(negedge clk);
    endtask

    task automatic t_no_hazard();
        integer stalls;
        do_reset();
        load(0, 6, 0, 0, 0);
        load(1, 9, 0, 0, 1);
        load(2, 7, 0, 0, 1);
        list_len = 3; max_iter = 1;
        kick();
        stalls = 0;
        chk("R8 idx0 first", row_first, 1);
        chk("R8 idx0 not last", row_last, 0);
        if (stall) stalls++;
        @(negedge clk);
        chk("R8 idx1 not first", row_first, 0);
        chk("R8 idx1 last", row_last, 1);
        chk("R7 idx1 addr", rd_addr[3:0], 3);
        if (stall) stalls++;
        @(negedge clk);
        chk("R7 other slot same addr", rd_en, 3'b010);
        chk("R7 other slot addr", rd_addr[7:4], 2);
        if (stall) stalls++;
        chk("R7 no stalls", stalls, 0);
        repeat (8) @(negedge clk);
    endtask

    task automatic t_iterations();
        integer reads, firsts;
        do_reset();
        load(0, 0, 0, 0, 1);
        load(1, 4, 0, 0, 1);
        list_len = 2; max_iter = 3; chk_ok = 0;
        kick();
        wait_done(reads, firsts);
        chk("R9 iter limit", iter_cnt, 3);
        chk("R9 read cycles", reads, 6);
        chk("R8 group starts", firsts, 6);
        @(negedge clk);
        max_iter = 3; chk_ok = 1;
        kick();
        wait_done(reads, firsts);
        chk("R9 early stop", iter_cnt, 1);
        chk("R9 early reads", reads, 2);
        @(negedge clk);
        max_iter = 0; chk_ok = 0;
        kick();
        wait_done(reads, firsts);
        chk("R9 zero limit", iter_cnt, 1);
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_mapping();
        t_idle_and_reject();
        t_hazard();
        t_no_hazard();
        t_iterations();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule